// File: doc/BRIEF.md
# Mode-Dependent Memory Map Decoder

This block turns a 16-bit address into a one-hot region select and an offset inside that region. The four regions are the on-chip RAM, the user ROM, a small bootloader ROM and external space. A bus fabric uses it to steer each access to the right memory and to give that memory a local address. The decoder models only the decode and its one piece of state. The memories and the CPU are outside it.

The 256-byte RAM starts at address 0 after reset. Software can move it to the start of any 4 KB block by writing a 4-bit position register. That register takes only the first write after reset. The 192-byte bootloader ROM at $BF40–$BFFF has mode-dependent visibility:

- In special bootstrap mode it is always in the map.
- In special test mode it appears only while the software enable is set.
- In the two normal modes it is never in the map.

The 8 KB user ROM sits at $E000–$FFFF and is gated by a configuration bit. Where regions overlap, a fixed priority picks one. All outputs are registered and appear one clock after the address.

Top module: `memmap_decoder`

## Requirements
- R1: While `rst` is high, `sel_o` is 4'b0000 and `offset_o` is 0. After reset the RAM position is 0, so with no write the RAM occupies $0000–$00FF.
- R2: With position register value P, an address with bits [15:12]==P and bits [11:8]==0 selects RAM (`sel_o`=4'b0001). The offset is address bits [7:0].
- R3: Only the first accepted write of `pos_data_i` after reset (`pos_we_i`=1) changes the RAM position. Every later write is ignored until the next reset.
- R4: In bootstrap mode (`mode_i`=2'b10), every address in $BF40–$BFFF selects the bootloader ROM (`sel_o`=4'b0010) with offset address−$BF40. This includes the reset vector bytes $BFFE and $BFFF, which give offsets $BE and $BF.
- R5: In normal single-chip mode (2'b00) and normal expanded mode (2'b01), the bootloader ROM is never selected, whatever the value of `boot_sw_en_i`. Its addresses fall to the next region that decodes there.
- R6: In test mode (2'b11), $BF40–$BFFF selects the bootloader ROM only while `boot_sw_en_i`=1. Otherwise those addresses fall through.
- R7: With `rom_en_i`=1, $E000–$FFFF selects the user ROM (`sel_o`=4'b0100) with offset address bits [12:0]. With `rom_en_i`=0, the user ROM is never selected.
- R8: Outside reset, exactly one select bit is high. The priority is RAM, then bootloader ROM, then user ROM, then external (`sel_o`=4'b1000). External space uses the full address as its offset.
- R9: `sel_o` and `offset_o` change only at a rising clock edge. They reflect the inputs sampled at that edge, using the RAM position held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Operating mode: 00 normal single-chip, 01 normal expanded, 10 special bootstrap, 11 special test |
| rom_en_i | input | 1 | User ROM enable configuration bit |
| boot_sw_en_i | input | 1 | Software enable for the bootloader ROM, used in test mode only |
| pos_we_i | input | 1 | Write strobe for the RAM position register |
| pos_data_i | input | 4 | New RAM position, which becomes address bits [15:12] of the RAM base |
| addr_i | input | 16 | Address to decode |
| sel_o | output | 4 | One-hot select: bit0 RAM, bit1 bootloader ROM, bit2 user ROM, bit3 external |
| offset_o | output | 16 | Offset of the address within the selected region |

## Verification
The position register is the only state in the block, so a wrong value shows up as RAM decoding in the wrong 4 KB block. A wrong lock bit shows up as a second write moving the RAM. Either fault appears one clock after the next address that probes the old or the new base. The bench probes both bases after each write and again after a second reset. The mode-gated boot window and the overlap priority are combinational ahead of the output register, so a fault there is visible on the very next output sample.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXPAND = 2'b01,
    MODE_BOOT   = 2'b10,
    MODE_TEST   = 2'b11
  } op_mode_e;

  localparam int NUM_REGIONS = 4;
  localparam int SEL_RAM  = 0;
  localparam int SEL_BOOT = 1;
  localparam int SEL_UROM = 2;
  localparam int SEL_EXT  = 3;

  function automatic logic boot_visible(op_mode_e m, logic sw_en);
    return (m == MODE_BOOT) || ((m == MODE_TEST) && sw_en);
  endfunction

endpackage

// File: rtl/memmap_pos_reg.sv
module memmap_pos_reg #(
  parameter int POS_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [POS_W-1:0] data_i,
  output logic [POS_W-1:0] pos_o
);

  logic [POS_W-1:0] pos_q;
  logic             locked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q    <= '0;
      locked_q <= 1'b0;
    end else if (we_i && !locked_q) begin
      pos_q    <= data_i;
      locked_q <= 1'b1;
    end
  end

  assign pos_o = pos_q;

  // R3
  pos_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> $stable(pos_q));

endmodule

// File: rtl/memmap_window.sv
module memmap_window #(
  parameter int ADDR_W = 16,
  parameter int BASE   = 0,
  parameter int SIZE   = 256
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] off_o
);

  localparam int LIMIT = BASE + SIZE;
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);

  logic [31:0] addr_wide;

  assign addr_wide = 32'(addr_i);
  assign hit_o = en_i && (addr_wide >= 32'(BASE)) && (addr_wide < 32'(LIMIT));
  assign off_o = addr_i - BASE_V;

endmodule

// File: rtl/memmap_prio.sv
module memmap_prio #(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic [N-1:0]        hit_i,
  input  logic [N-1:0][W-1:0] off_i,
  output logic [N-1:0]        sel_o,
  output logic [W-1:0]        off_o
);

  for (genvar i = 0; i < N; i++) begin : g_rank
    if (i == 0) begin : g_top
      assign sel_o[i] = hit_i[i];
    end else begin : g_lower
      assign sel_o[i] = hit_i[i] & ~(|hit_i[i-1:0]);
    end
  end

  always_comb begin
    off_o = '0;
    for (int k = 0; k < N; k++) begin
      off_o = off_o | (off_i[k] & {W{sel_o[k]}});
    end
  end

endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BLOCK_AW  = 12,
  parameter int RAM_AW    = 8,
  parameter int BOOT_BASE = 'hBF40,
  parameter int BOOT_SIZE = 192,
  parameter int UROM_BASE = 'hE000,
  parameter int UROM_SIZE = 8192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_i,
  input  logic              rom_en_i,
  input  logic              boot_sw_en_i,
  input  logic              pos_we_i,
  input  logic [ADDR_W-BLOCK_AW-1:0] pos_data_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_REGIONS-1:0] sel_o,
  output logic [ADDR_W-1:0] offset_o
);

  localparam int POS_W = ADDR_W - BLOCK_AW;
  localparam int GAP_W = BLOCK_AW - RAM_AW;
  localparam logic [ADDR_W-1:0] VEC_ADDR = ADDR_W'(BOOT_BASE + BOOT_SIZE - 2);

  op_mode_e mode;
  logic [POS_W-1:0] ram_pos;
  logic [NUM_REGIONS-1:0] hit;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] off;
  logic [NUM_REGIONS-1:0] sel_d;
  logic [ADDR_W-1:0] off_d;
  logic boot_en;

  assign mode = op_mode_e'(mode_i);
  assign boot_en = boot_visible(mode, boot_sw_en_i);

  memmap_pos_reg #(.POS_W(POS_W)) u_pos (
    .clk    (clk),
    .rst    (rst),
    .we_i   (pos_we_i),
    .data_i (pos_data_i),
    .pos_o  (ram_pos)
  );

  // RAM window: movable in block steps
  assign hit[SEL_RAM] = (addr_i[ADDR_W-1:BLOCK_AW] == ram_pos) &&
                        (addr_i[BLOCK_AW-1:RAM_AW] == {GAP_W{1'b0}});
  assign off[SEL_RAM] = {{(ADDR_W-RAM_AW){1'b0}}, addr_i[RAM_AW-1:0]};

  memmap_window #(.ADDR_W(ADDR_W), .BASE(BOOT_BASE), .SIZE(BOOT_SIZE)) u_boot (
    .en_i   (boot_en),
    .addr_i (addr_i),
    .hit_o  (hit[SEL_BOOT]),
    .off_o  (off[SEL_BOOT])
  );

  memmap_window #(.ADDR_W(ADDR_W), .BASE(UROM_BASE), .SIZE(UROM_SIZE)) u_urom (
    .en_i   (rom_en_i),
    .addr_i (addr_i),
    .hit_o  (hit[SEL_UROM]),
    .off_o  (off[SEL_UROM])
  );

  assign hit[SEL_EXT] = 1'b1;
  assign off[SEL_EXT] = addr_i;

  memmap_prio #(.N(NUM_REGIONS), .W(ADDR_W)) u_prio (
    .hit_i (hit),
    .off_i (off),
    .sel_o (sel_d),
    .off_o (off_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o    <= '0;
      offset_o <= '0;
    end else begin
      sel_o    <= sel_d;
      offset_o <= off_d;
    end
  end

  // R8
  one_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $onehot(sel_o));

  // R5
  normal_noboot_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_SINGLE || mode_i == MODE_EXPAND) |=> !sel_o[SEL_BOOT]);

  // R7
  urom_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !rom_en_i |=> !sel_o[SEL_UROM]);

  // R4
  boot_vector_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_BOOT && addr_i[ADDR_W-1:1] == VEC_ADDR[ADDR_W-1:1])
    |=> sel_o[SEL_BOOT]);

  // R2
  ram_place_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_i[ADDR_W-1:BLOCK_AW] == ram_pos && addr_i[BLOCK_AW-1:RAM_AW] == '0)
    |=> (sel_o[SEL_RAM] && offset_o[RAM_AW-1:0] == $past(addr_i[RAM_AW-1:0])));

endmodule

// File: tb/sim_memmap_decoder.sv
`timescale 1ns/1ps
module sim_memmap_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode_i = 2'b00;
  logic        rom_en_i = 1'b1;
  logic        boot_sw_en_i = 1'b0;
  logic        pos_we_i = 1'b0;
  logic [3:0]  pos_data_i = 4'h0;
  logic [15:0] addr_i = 16'h0000;
  logic [3:0]  sel_o;
  logic [15:0] offset_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  memmap_decoder u0 (
    .clk(clk), .rst(rst), .mode_i(mode_i), .rom_en_i(rom_en_i),
    .boot_sw_en_i(boot_sw_en_i), .pos_we_i(pos_we_i), .pos_data_i(pos_data_i),
    .addr_i(addr_i), .sel_o(sel_o), .offset_o(offset_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired sel=%h off=%h exp finish", sel_o, offset_o);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // {req, mode, rom_en, sw_en, addr, exp_sel, exp_off}
  localparam int NV = 16;
  localparam logic [43:0] VEC [NV] = '{
    {4'd2, 2'b00, 1'b1, 1'b0, 16'h0000, 4'b0001, 16'h0000}, // R2 R1 RAM at 0
    {4'd2, 2'b00, 1'b1, 1'b0, 16'h00FF, 4'b0001, 16'h00FF}, // R2 top byte
    {4'd8, 2'b00, 1'b1, 1'b0, 16'h0100, 4'b1000, 16'h0100}, // R8 just past RAM
    {4'd4, 2'b10, 1'b1, 1'b0, 16'hBF40, 4'b0010, 16'h0000}, // R4 boot start
    {4'd4, 2'b10, 1'b1, 1'b0, 16'hBFFE, 4'b0010, 16'h00BE}, // R4 vector hi
    {4'd4, 2'b10, 1'b1, 1'b0, 16'hBFFF, 4'b0010, 16'h00BF}, // R4 vector lo
    {4'd4, 2'b10, 1'b1, 1'b0, 16'hBF3F, 4'b1000, 16'hBF3F}, // R4 below boot
    {4'd5, 2'b00, 1'b1, 1'b0, 16'hBF40, 4'b1000, 16'hBF40}, // R5 single-chip
    {4'd5, 2'b01, 1'b1, 1'b1, 16'hBFFF, 4'b1000, 16'hBFFF}, // R5 expanded, sw ignored
    {4'd6, 2'b11, 1'b1, 1'b0, 16'hBF80, 4'b1000, 16'hBF80}, // R6 test, off
    {4'd6, 2'b11, 1'b1, 1'b1, 16'hBF80, 4'b0010, 16'h0040}, // R6 test, on
    {4'd7, 2'b00, 1'b1, 1'b0, 16'hE000, 4'b0100, 16'h0000}, // R7 urom start
    {4'd7, 2'b00, 1'b1, 1'b0, 16'hFFFF, 4'b0100, 16'h1FFF}, // R7 urom end
    {4'd7, 2'b00, 1'b0, 1'b0, 16'hFFFF, 4'b1000, 16'hFFFF}, // R7 urom disabled
    {4'd7, 2'b10, 1'b0, 1'b0, 16'hDFFF, 4'b1000, 16'hDFFF}, // R7 below urom
    {4'd8, 2'b00, 1'b1, 1'b0, 16'hC000, 4'b1000, 16'hC000}  // R8 external
  };

  task automatic check(input string tag, input logic [3:0] es, input logic [15:0] eo);
    checks++;
    if (sel_o !== es || offset_o !== eo) begin
      errors++;
      $display("FAIL %s sel=%b exp %b off=%h exp %h", tag, sel_o, es, offset_o, eo);
    end
  endtask

  task automatic probe(input logic [15:0] a, input string tag,
                       input logic [3:0] es, input logic [15:0] eo);
    @(negedge clk);
    addr_i = a;
    @(negedge clk);
    check(tag, es, eo);
  endtask

  task automatic write_pos(input logic [3:0] p);
    @(negedge clk);
    pos_we_i = 1'b1;
    pos_data_i = p;
    @(negedge clk);
    pos_we_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 in reset", 4'b0000, 16'h0000);
    rst = 1'b0;
  endtask

  initial begin
    addr_i = 16'h1234;
    do_reset();

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode_i       = VEC[i][39:38];
      rom_en_i     = VEC[i][37];
      boot_sw_en_i = VEC[i][36];
      addr_i       = VEC[i][35:20];
      @(negedge clk);
      checks++;
      if (sel_o !== VEC[i][19:16] || offset_o !== VEC[i][15:0]) begin
        errors++;
        $display("FAIL R%0d vec %0d sel=%b exp %b off=%h exp %h", VEC[i][43:40], i,
                 sel_o, VEC[i][19:16], offset_o, VEC[i][15:0]);
      end
    end

    mode_i = 2'b00; rom_en_i = 1'b1; boot_sw_en_i = 1'b0;

    // R9: output holds until the rising edge
    probe(16'h0100, "R9 setup", 4'b1000, 16'h0100);
    @(negedge clk);
    addr_i = 16'h0010;
    #1.5;
    check("R9 before edge", 4'b1000, 16'h0100);
    @(negedge clk);
    check("R9 after edge", 4'b0001, 16'h0010);

    // R3 / R2: move RAM to block B
    write_pos(4'hB);
    probe(16'hB000, "R2 moved base", 4'b0001, 16'h0000);
    probe(16'hB0FF, "R2 moved top", 4'b0001, 16'h00FF);
    probe(16'h0000, "R2 old base free", 4'b1000, 16'h0000);
    write_pos(4'h2);
    probe(16'h2000, "R3 second write ignored", 4'b1000, 16'h2000);
    probe(16'hB080, "R3 position kept", 4'b0001, 16'h0080);

    // R1: reset restores position 0 and reopens the register
    do_reset();
    probe(16'h0000, "R1 base back at 0", 4'b0001, 16'h0000);
    probe(16'hB000, "R1 block B free", 4'b1000, 16'hB000);

    // R8: RAM overrides user ROM
    write_pos(4'hE);
    probe(16'hE000, "R8 ram over urom", 4'b0001, 16'h0000);
    probe(16'hE0FF, "R8 ram over urom top", 4'b0001, 16'h00FF);
    probe(16'hE100, "R8 urom after ram", 4'b0100, 16'h0100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule